// File: doc/BRIEF.md
# Key-Guarded Peripheral Reset Pulse Controller

This block drives a bank of per-peripheral reset lines from a small register port. Software writes a word whose set bits name the peripherals to reset, and each named peripheral's reset line pulses high for a fixed number of clock cycles. Such writes take effect only while a guard is open. The guard is opened and closed by writing one of two 32-bit key values to a dedicated lock word. Any other value leaves the guard as it is, and reset requests made while it is closed vanish without effect.

Five 32-bit request words (word addresses 0 to 4) cover 160 reset lines. Line `32*b + k` belongs to bit k of word b. The lock word sits directly after them at word address 5, and a one-bit self-clearing soft reset for the battery-backed domain sits at word address 6. The guard is a two-state machine, LK_LOCKED and LK_UNLOCKED. LK_LOCKED goes to LK_UNLOCKED on a write of the unlock key, and LK_UNLOCKED goes back to LK_LOCKED on a write of the lock key. Each reset line has its own pulse machine with two states, PS_IDLE and PS_HOLD. A request moves PS_IDLE to PS_HOLD or restarts PS_HOLD, and PS_HOLD returns to PS_IDLE when its count runs out. Reads are combinational on the address.

Top module: `periph_reset_guard`

## Requirements
- R1: After reset the guard is locked: the lock word reads 0, all 160 reset lines and the soft-reset line are low, and every request word reads 0.
- R2: A write of 0xA6382D4C to word address 5 opens the guard; from the next cycle the lock word reads 1 (bit 0 set, other bits 0).
- R3: A write of 0xA6382D4D to word address 5 closes the guard; from the next cycle the lock word reads 0.
- R4: A write of any other value to word address 5 leaves the guard state unchanged, whether it is open or closed.
- R5: While the guard is closed, writes to word addresses 0 to 4 start no pulse and change no read-back value.
- R6: While the guard is open, a write of data D to word address b (0 to 4) drives line 32*b+k high for exactly 4 cycles, starting the cycle after the write, for every bit k set in D; bits that are 0 in D leave their lines unchanged.
- R7: Word address b (0 to 4) reads back bit k as 1 while line 32*b+k is high and 0 otherwise, so a requested bit reads 0 once its pulse has ended.
- R8: A new request for a line whose pulse is still running restarts its count, so the line stays high for 4 cycles after the later write.
- R9: A write to word address 6 with bit 0 set drives the soft-reset line high for 4 cycles, whether the guard is open or closed; word 6 reads bit 0 as 1 during the pulse and 0 after; other data bits are ignored.
- R10: Word address 7 reads 0, and writes to it change no output or read-back value.
- R11: Writes to the request words and the soft-reset word do not change the guard state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| periph_rst | output | 160 | Per-peripheral reset pulses |
| bat_soft_rst | output | 1 | Battery-domain soft-reset pulse |

## Verification
The in-RTL properties check the guard transitions on every cycle: the unlock key opens it, the lock key closes it, and any other value or an idle cycle leaves it unchanged. They also check that a request always starts a pulse on the next cycle, that no line rises without a request, and that a write to a request word while locked raises no line. The exact pulse length, the restart on a repeated request, the read-back of running pulses, the soft reset being independent of the guard, and the inert unmapped word are shown only by the bench. Its reference model follows every line cycle by cycle through directed sequences and a long random mix of keys, near-keys and requests.

// File: rtl/prr_pkg.sv
package prr_pkg;

    typedef enum logic {
        LK_LOCKED   = 1'b0,
        LK_UNLOCKED = 1'b1
    } lock_state_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_HOLD = 1'b1
    } pulse_state_t;

endpackage

// File: rtl/prr_lock_fsm.sv
module prr_lock_fsm
    import prr_pkg::*;
#(
    parameter int              KEY_W      = 32,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 32'hA638_2D4C,
    parameter logic [KEY_W-1:0] LOCK_KEY   = 32'hA638_2D4D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    output logic             unlocked
);

    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (key_wr && key_data == UNLOCK_KEY) begin
                    state_d = LK_UNLOCKED;
                end
            end
            LK_UNLOCKED: begin
                if (key_wr && key_data == LOCK_KEY) begin
                    state_d = LK_LOCKED;
                end
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unlocked = (state_q == LK_UNLOCKED);
    end

    AST_UNLOCK_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == UNLOCK_KEY) |=> unlocked); // R2

    AST_LOCK_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == LOCK_KEY) |=> !unlocked); // R3

    AST_OTHER_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != LOCK_KEY && key_data != UNLOCK_KEY) |=> $stable(unlocked)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(unlocked)); // R11

endmodule

// File: rtl/prr_pulse_bank.sv
module prr_pulse_bank
    import prr_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] fire,
    output logic [WIDTH-1:0] active
);

    localparam int CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN - 1);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        pulse_state_t     st_q, st_d;
        logic [CNT_W-1:0] cnt_q, cnt_d;

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q  <= PS_IDLE;
                cnt_q <= '0;
            end else begin
                st_q  <= st_d;
                cnt_q <= cnt_d;
            end
        end

        // transitions
        always_comb begin
            st_d  = st_q;
            cnt_d = cnt_q;
            unique case (st_q)
                PS_IDLE: begin
                    if (fire[i]) begin
                        st_d  = PS_HOLD;
                        cnt_d = LOAD_VAL;
                    end
                end
                PS_HOLD: begin
                    if (fire[i]) begin
                        cnt_d = LOAD_VAL;
                    end else if (cnt_q == '0) begin
                        st_d = PS_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    st_d  = PS_IDLE;
                    cnt_d = '0;
                end
            endcase
        end

        // outputs
        always_comb begin
            active[i] = (st_q == PS_HOLD);
        end

        AST_FIRE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> active[i]); // R6

        AST_NO_SPONTANEOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (!active[i] && !fire[i]) |=> !active[i]); // R6
    end

endmodule

// File: rtl/periph_reset_guard.sv
module periph_reset_guard
    import prr_pkg::*;
#(
    parameter int                NUM_BANKS  = 5,
    parameter int                BANK_W     = 32,
    parameter int                PULSE_LEN  = 4,
    parameter int                ADDR_W     = 3,
    parameter logic [BANK_W-1:0] UNLOCK_KEY = 32'hA638_2D4C,
    parameter logic [BANK_W-1:0] LOCK_KEY   = 32'hA638_2D4D
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic [NUM_BANKS*BANK_W-1:0] periph_rst,
    output logic                        bat_soft_rst
);

    localparam int                LINES     = NUM_BANKS * BANK_W;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] SOFT_ADDR = ADDR_W'(NUM_BANKS + 1);

    logic             unlocked;
    logic             key_wr;
    logic             soft_fire;
    logic [LINES-1:0] line_fire;

    assign key_wr    = bus_wr && (bus_addr == LOCK_ADDR);
    assign soft_fire = bus_wr && (bus_addr == SOFT_ADDR) && bus_wdata[0];

    prr_lock_fsm #(
        .KEY_W      (BANK_W),
        .UNLOCK_KEY (UNLOCK_KEY),
        .LOCK_KEY   (LOCK_KEY)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .unlocked (unlocked)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_hit;
        assign bank_hit = bus_wr && unlocked && (bus_addr == ADDR_W'(b));
        assign line_fire[b*BANK_W +: BANK_W] = bank_hit ? bus_wdata : '0;

        prr_pulse_bank #(
            .WIDTH     (BANK_W),
            .PULSE_LEN (PULSE_LEN)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire   (line_fire[b*BANK_W +: BANK_W]),
            .active (periph_rst[b*BANK_W +: BANK_W])
        );
    end

    prr_pulse_bank #(
        .WIDTH     (1),
        .PULSE_LEN (PULSE_LEN)
    ) u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (soft_fire),
        .active (bat_soft_rst)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(b)) begin
                bus_rdata = periph_rst[b*BANK_W +: BANK_W];
            end
        end
        if (bus_addr == LOCK_ADDR) begin
            bus_rdata = {{(BANK_W-1){1'b0}}, unlocked};
        end
        if (bus_addr == SOFT_ADDR) begin
            bus_rdata = {{(BANK_W-1){1'b0}}, bat_soft_rst};
        end
    end

    AST_LOCKED_WRITE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked && bus_addr < LOCK_ADDR)
        |=> ((periph_rst & ~$past(periph_rst)) == '0)); // R5

    AST_SOFT_WRITE_KEEPS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SOFT_ADDR) |=> $stable(unlocked)); // R11

endmodule

// File: tb/periph_reset_guard_bench.sv
`timescale 1ns/1ps
module periph_reset_guard_bench;

    localparam int NB    = 5;
    localparam int BW    = 32;
    localparam int LINES = NB * BW;
    localparam int PLEN  = 4;
    localparam logic [31:0] K_OPEN  = 32'hA638_2D4C;
    localparam logic [31:0] K_CLOSE = 32'hA638_2D4D;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [LINES-1:0] periph_rst;
    logic             bat_soft_rst;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model
    int cnt_m [LINES];
    int soft_m;
    bit open_m;

    always #2.5 clk = ~clk;

    periph_reset_guard u_periph_reset_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .periph_rst   (periph_rst),
        .bat_soft_rst (bat_soft_rst)
    );

    function automatic logic [LINES-1:0] exp_lines();
        logic [LINES-1:0] v;
        for (int i = 0; i < LINES; i++) v[i] = (cnt_m[i] > 0);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [LINES-1:0] v;
        v = exp_lines();
        if (a < 3'(NB)) return v[a*BW +: BW];
        if (a == 3'd5) return {31'b0, open_m};
        if (a == 3'd6) return {31'b0, soft_m > 0};
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) cnt_m[i] = 0;
            soft_m = 0;
            open_m = 1'b0;
        end else begin
            for (int i = 0; i < LINES; i++) if (cnt_m[i] > 0) cnt_m[i]--;
            if (soft_m > 0) soft_m--;
            if (bus_wr) begin
                if (bus_addr < 3'(NB)) begin
                    if (open_m)
                        for (int k = 0; k < BW; k++)
                            if (bus_wdata[k]) cnt_m[bus_addr*BW + k] = PLEN;
                end else if (bus_addr == 3'd5) begin
                    if (bus_wdata == K_OPEN) open_m = 1'b1;
                    else if (bus_wdata == K_CLOSE) open_m = 1'b0;
                end else if (bus_addr == 3'd6) begin
                    if (bus_wdata[0]) soft_m = PLEN;
                end
            end
        end
    end

    // every-cycle output comparison
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            #1;
            n_cmp++;
            if (periph_rst !== exp_lines()) begin
                n_bad++;
                $display("FAIL R6 lines: actual %h expected %h", periph_rst, exp_lines());
            end
            n_cmp++;
            if (bat_soft_rst !== (soft_m > 0)) begin
                n_bad++;
                $display("FAIL R9 soft line: actual %0b expected %0b", bat_soft_rst, soft_m > 0);
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        n_cmp++;
        if (bus_rdata !== exp_read(a)) begin
            n_bad++;
            $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, bus_rdata, exp_read(a));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R1");
        n_cmp++;
        if (periph_rst !== '0 || bat_soft_rst !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 outputs: actual %h/%0b expected 0/0", periph_rst, bat_soft_rst);
        end

        // R5 locked writes ignored
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, "R5");
        wr(3'd4, 32'h8000_0001);
        rd(3'd4, "R5");

        // R4 near-key while locked
        wr(3'd5, K_OPEN ^ 32'h0000_0100);
        rd(3'd5, "R4");

        // R2 unlock
        wr(3'd5, K_OPEN);
        rd(3'd5, "R2");

        // R6 / R7 pulse and readback
        wr(3'd2, 32'h0000_0005);
        rd(3'd2, "R7");
        idle(4);
        rd(3'd2, "R7");

        // R8 restart while running
        wr(3'd0, 32'h0000_0001);
        wr(3'd0, 32'h0000_0001);
        idle(1);
        rd(3'd0, "R8");

        // R11 guard stays open after requests
        rd(3'd5, "R11");

        // R4 near-key while unlocked
        wr(3'd5, K_CLOSE ^ 32'h8000_0000);
        rd(3'd5, "R4");

        // R3 lock
        wr(3'd5, K_CLOSE);
        rd(3'd5, "R3");

        // R9 soft reset while locked, extra bits ignored
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, "R9");
        idle(4);
        rd(3'd6, "R9");
        wr(3'd6, 32'hFFFF_FFFE);
        rd(3'd6, "R9");

        // R10 unmapped word
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, "R10");
        rd(3'd5, "R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic [2:0]  a;
            logic [31:0] d;
            r = $urandom % 8;
            a = 3'($urandom % 8);
            if (r < 3) begin
                @(negedge clk);
                rd(a, "R7");
            end else begin
                d = $urandom & $urandom & $urandom;
                if (a == 3'd5) begin
                    case ($urandom % 4)
                        0: d = K_OPEN;
                        1: d = K_CLOSE;
                        2: d = K_OPEN ^ (32'h1 << ($urandom % 32));
                        default: ;
                    endcase
                end
                @(negedge clk);
                bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        idle(6);
        rd(3'd5, "R4");
        finish_run();
    end

endmodule